// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a high-rate input clock by a programmable ratio N = P*B + A and emits one single-cycle pulse per N input cycles. The pulse goes to a phase detector, where it is compared against a divided reference. A dual-modulus prescaler is built as a down-counter. It divides by P+1 while a swallow counter is still non-zero and by P once the swallow counter is exhausted. A main counter counts prescaler cycles and closes each output period after B of them. The base modulus P is 32 or 64, chosen by a select input.

The three settings are sampled only at an output-period boundary, so reprogramming never produces a truncated or stretched period. A main count below 3 is raised to 3. A swallow count larger than the effective main count is clamped to the main count, and a configuration-error flag is raised for that period.

Top module: `pswallow_div`

## Requirements
- R1: With `pre_hi_i` = 0 (P = 32), consecutive `div_pulse_o` pulses are exactly 32*B + A input clock cycles apart, for legal settings (3 <= B, A <= B).
- R2: With `pre_hi_i` = 1 (P = 64), consecutive pulses are exactly 64*B + A cycles apart.
- R3: `div_pulse_o` is high for exactly one clock cycle per output period.
- R4: When `swallow_i` exceeds the effective main count, the period uses A equal to that main count, and `cfg_err_o` is 1 for that period. For legal settings `cfg_err_o` is 0.
- R5: A `main_i` value of 0, 1 or 2 gives the same period as a value of 3.
- R6: Changes to `swallow_i`, `main_i` and `pre_hi_i` made inside a period do not alter that period. The settings present on the clock edge that raises `div_pulse_o` govern the period that begins at that edge, and `cfg_err_o` changes only on that edge.
- R7: Inside a period, each prescaler cycle lasts P+1 input cycles for the first A prescaler cycles and P input cycles for the rest.
- R8: While `rst_n` is low, `div_pulse_o` and `cfg_err_o` are 0.
- R9: The extreme swallow settings are exact. A = 0 gives P*B, and A = B gives (P+1)*B, including A = 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| swallow_i | input | 7 | Swallow count A |
| main_i | input | 11 | Main count B |
| pre_hi_i | input | 1 | Prescaler select: 0 gives 32/33, 1 gives 64/65 |
| div_pulse_o | output | 1 | One-cycle pulse per divided period |
| cfg_err_o | output | 1 | Swallow count was clamped for the current period |

## Verification
The assertions check several properties on every cycle. Each prescaler cycle lasts P+1 or P input cycles according to whether swallow counts remain. The swallow count never exceeds the remaining main count, and the main count never reaches zero inside a period. The pulse is one cycle wide, and the error flag moves only at a period boundary. Only the bench scenarios can show that the full period length equals P*B + A for specific settings. The same holds for the clamp of small main counts, the clamp of oversize swallow counts, and mid-period reprogramming being deferred to the next period.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  // default field widths and prescaler moduli (as powers of two)
  parameter int unsigned SWL_W      = 7;
  parameter int unsigned MAIN_W     = 11;
  parameter int unsigned PRE_LO_LOG = 5;
  parameter int unsigned PRE_HI_LOG = 6;
  parameter int unsigned MAIN_MIN   = 3;
endpackage

// File: rtl/pswallow_rst_sync.sv
module pswallow_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/pswallow_cfg.sv
// Clamps the raw settings and holds the ones governing the running period.
module pswallow_cfg #(
  parameter int unsigned A_W      = 7,
  parameter int unsigned B_W      = 11,
  parameter int unsigned MAIN_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] swallow_raw,
  input  logic [B_W-1:0] main_raw,
  input  logic           hi_raw,
  output logic [A_W-1:0] swallow_eff,
  output logic [B_W-1:0] main_eff,
  output logic           hi_now,
  output logic           hi_q,
  output logic           err_q
);
  localparam logic [B_W-1:0] MIN_B = B_W'(MAIN_MIN);

  logic err_raw;
  logic hi_d, err_d;

  always_comb begin
    main_eff    = (main_raw < MIN_B) ? MIN_B : main_raw;
    err_raw     = B_W'(swallow_raw) > main_eff;
    swallow_eff = err_raw ? main_eff[A_W-1:0] : swallow_raw;
    hi_now      = load ? hi_raw : hi_q;
  end

  always_comb begin
    hi_d  = hi_q;
    err_d = err_q;
    if (load) begin
      hi_d  = hi_raw;
      err_d = err_raw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      hi_q  <= hi_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/pswallow_prescaler.sv
// Dual-modulus down-counter: terminal count every P or P+1 cycles.
module pswallow_prescaler #(
  parameter int unsigned LO_LOG = 5,
  parameter int unsigned HI_LOG = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic hi_sel,
  input  logic plus_one,
  output logic tc
);
  localparam int unsigned PC_W = HI_LOG + 1;
  localparam logic [PC_W-1:0] P_LO = PC_W'(1) << LO_LOG;
  localparam logic [PC_W-1:0] P_HI = PC_W'(1) << HI_LOG;

  logic [PC_W-1:0] cnt_q, cnt_d, base;

  always_comb begin
    tc    = (cnt_q == '0);
    base  = hi_sel ? P_HI : P_LO;
    cnt_d = cnt_q - PC_W'(1);
    if (load || tc) begin
      cnt_d = plus_one ? base : (base - PC_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pswallow_ctrl.sv
// Swallow and main counters; decide modulus and close the period.
module pswallow_ctrl #(
  parameter int unsigned A_W = 7,
  parameter int unsigned B_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tc,
  input  logic [A_W-1:0] swallow_eff,
  input  logic [B_W-1:0] main_eff,
  output logic           load,
  output logic           plus_one,
  output logic           primed_q,
  output logic [A_W-1:0] swl_q,
  output logic [B_W-1:0] main_q,
  output logic           pulse_q
);
  logic           wrap;
  logic [A_W-1:0] swl_dec, swl_d;
  logic [B_W-1:0] main_d;
  logic           primed_d;

  always_comb begin
    wrap     = primed_q && tc && (main_q == B_W'(1));
    load     = !primed_q || wrap;
    swl_dec  = swl_q - A_W'(swl_q != '0);
    plus_one = load ? (swallow_eff != '0) : (swl_dec != '0);
    swl_d    = swl_q;
    main_d   = main_q;
    primed_d = 1'b1;
    if (load) begin
      swl_d  = swallow_eff;
      main_d = main_eff;
    end else if (tc) begin
      swl_d  = swl_dec;
      main_d = main_q - B_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      swl_q    <= '0;
      main_q   <= '0;
      pulse_q  <= 1'b0;
    end else begin
      primed_q <= primed_d;
      swl_q    <= swl_d;
      main_q   <= main_d;
      pulse_q  <= wrap;
    end
  end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter int unsigned A_W      = SWL_W,
  parameter int unsigned B_W      = MAIN_W,
  parameter int unsigned LO_LOG   = PRE_LO_LOG,
  parameter int unsigned HI_LOG   = PRE_HI_LOG,
  parameter int unsigned B_FLOOR  = MAIN_MIN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] swallow_i,
  input  logic [B_W-1:0] main_i,
  input  logic           pre_hi_i,
  output logic           div_pulse_o,
  output logic           cfg_err_o
);
  logic           rst_sync_n;
  logic           load, plus_one, tc, primed_q;
  logic           hi_now, hi_q, err_q, pulse_q;
  logic [A_W-1:0] swallow_eff, swl_q;
  logic [B_W-1:0] main_eff, main_q;

  pswallow_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pswallow_cfg #(.A_W(A_W), .B_W(B_W), .MAIN_MIN(B_FLOOR)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .load(load),
    .swallow_raw(swallow_i), .main_raw(main_i), .hi_raw(pre_hi_i),
    .swallow_eff(swallow_eff), .main_eff(main_eff),
    .hi_now(hi_now), .hi_q(hi_q), .err_q(err_q)
  );

  pswallow_prescaler #(.LO_LOG(LO_LOG), .HI_LOG(HI_LOG)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .hi_sel(hi_now),
    .plus_one(plus_one), .tc(tc)
  );

  pswallow_ctrl #(.A_W(A_W), .B_W(B_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .tc(tc),
    .swallow_eff(swallow_eff), .main_eff(main_eff),
    .load(load), .plus_one(plus_one), .primed_q(primed_q),
    .swl_q(swl_q), .main_q(main_q), .pulse_q(pulse_q)
  );

  assign div_pulse_o = pulse_q;
  assign cfg_err_o   = err_q;
endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk #(
  parameter int unsigned A_W    = 7,
  parameter int unsigned B_W    = 11,
  parameter int unsigned LO_LOG = 5,
  parameter int unsigned HI_LOG = 6
) (
  input logic           clk,
  input logic           rst_sync_n,
  input logic           primed_q,
  input logic           tc,
  input logic           load,
  input logic           hi_q,
  input logic [A_W-1:0] swl_q,
  input logic [B_W-1:0] main_q,
  input logic           div_pulse_o,
  input logic           cfg_err_o
);
  localparam int unsigned G_W = HI_LOG + 2;
  logic [G_W-1:0] gap_q;
  logic [G_W-1:0] p_len;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)      gap_q <= '0;
    else if (load || tc)  gap_q <= '0;
    else                  gap_q <= gap_q + G_W'(1);
  end

  assign p_len = hi_q ? (G_W'(1) << HI_LOG) : (G_W'(1) << LO_LOG);

  // R7: prescaler cycle is P+1 while swallow counts remain, else P
  a_r7_modulus: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (primed_q && tc) |-> (gap_q + G_W'(1) == p_len + G_W'(swl_q != '0)));

  // R4: swallow never exceeds remaining main count
  a_r4_swallow_le_main: assert property (@(posedge clk) disable iff (!rst_sync_n)
    primed_q |-> (B_W'(swl_q) <= main_q));

  // R5: main count stays non-zero inside a period
  a_r5_main_nonzero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    primed_q |-> (main_q != '0));

  // R3: pulse lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    div_pulse_o |=> !div_pulse_o);

  // R6: error flag moves only at a period boundary
  a_r6_err_boundary: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(primed_q) && !div_pulse_o) |-> $stable(cfg_err_o));
endmodule

bind pswallow_div pswallow_div_chk #(
  .A_W(A_W), .B_W(B_W), .LO_LOG(LO_LOG), .HI_LOG(HI_LOG)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .primed_q(primed_q), .tc(tc),
  .load(load), .hi_q(hi_q), .swl_q(swl_q), .main_q(main_q),
  .div_pulse_o(div_pulse_o), .cfg_err_o(cfg_err_o)
);

// File: tb/test_pswallow_div.sv
`timescale 1ns/1ps
module test_pswallow_div;
  logic        clk;
  logic        rst_n;
  logic [6:0]  swallow_i;
  logic [10:0] main_i;
  logic        pre_hi_i;
  logic        div_pulse_o;
  logic        cfg_err_o;

  int n_chk;
  int n_bad;

  pswallow_div i_pswallow_div (
    .clk(clk), .rst_n(rst_n), .swallow_i(swallow_i), .main_i(main_i),
    .pre_hi_i(pre_hi_i), .div_pulse_o(div_pulse_o), .cfg_err_o(cfg_err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_n(input int a, input int b, input bit hi);
    int bm, ae, p;
    bm = (b < 3) ? 3 : b;
    ae = (a > bm) ? bm : a;
    p  = hi ? 64 : 32;
    return p * bm + ae;
  endfunction

  task automatic wait_pulse();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!div_pulse_o && guard < 150000);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse_o && n < 150000);
  endtask

  task automatic set_cfg(input int a, input int b, input bit hi);
    swallow_i = 7'(a);
    main_i    = 11'(b);
    pre_hi_i  = hi;
  endtask

  // apply settings, let them load at the next boundary, measure one period
  task automatic run_cfg(input int a, input int b, input bit hi,
                         input string req, input int err_exp);
    int n;
    wait_pulse();
    set_cfg(a, b, hi);
    wait_pulse();
    if (err_exp >= 0) chk(int'(cfg_err_o), err_exp, req);
    measure(n);
    chk(n, exp_n(a, b, hi), req);
  endtask

  initial begin
    #950000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    set_cfg(0, 3, 1'b0);
    repeat (5) @(negedge clk);
    // R8: outputs quiet in reset
    chk(int'(div_pulse_o), 0, "R8 pulse");
    chk(int'(cfg_err_o), 0, "R8 err");
    rst_n = 1'b1;

    // R1 R2 R7: sweep of legal settings for both prescalers
    for (int h = 0; h < 2; h++) begin
      for (int b = 3; b <= 6; b++) begin
        for (int a = 0; a <= b; a++) begin
          run_cfg(a, b, h[0], h ? "R2 R7 ratio" : "R1 R7 ratio", 0);
        end
      end
    end

    // R5: small main counts behave as 3
    run_cfg(1, 0, 1'b0, "R5 B=0", 0);
    run_cfg(2, 1, 1'b1, "R5 B=1", 0);
    run_cfg(3, 2, 1'b0, "R5 B=2", 0);

    // R4: oversize swallow clamped and flagged, then legal clears flag
    run_cfg(9, 5, 1'b0, "R4 clamp", 1);
    run_cfg(5, 2, 1'b1, "R4 clamp min", 1);
    run_cfg(2, 5, 1'b0, "R4 legal", 0);

    // R9: extremes of swallow count
    run_cfg(127, 127, 1'b0, "R9 A=B=127", 0);
    run_cfg(0, 200, 1'b1, "R9 A=0", 0);

    // R6: mid-period change is deferred
    wait_pulse();
    set_cfg(3, 4, 1'b0);
    wait_pulse();
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 50) set_cfg(9, 5, 1'b1);
    end while (!div_pulse_o && n < 150000);
    chk(n, exp_n(3, 4, 1'b0), "R6 deferred");
    chk(int'(cfg_err_o), 1, "R6 err at boundary");
    measure(n);
    chk(n, exp_n(9, 5, 1'b1), "R6 applied");
    // R3: pulse low the cycle after a pulse
    @(negedge clk);
    chk(int'(div_pulse_o), 0, "R3 width");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule